// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an operand addressing request into a memory address. It first forms a 16-bit effective offset from the addressing mode. The offset can be a displacement taken straight from the instruction, one pointer register, a base register plus an index register, or either of the last two with a displacement added. The displacement is 8 or 16 bits wide. The block then picks one of four segment values, moves it four bit positions to the left, and adds the offset to it. The result is a 20-bit physical address.

The whole path is combinational. A parameter, `REG_OUT`, places a register stage at the outputs. By default that stage is present, so the outputs follow the inputs of the previous clock edge. The register stage clears under a synchronous active-low reset. The values of the pointer registers and segment registers enter as plain inputs. The block stores no architectural state.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_o` equals `(segment << 4) + ofs_o`, kept to 20 bits. The segment is the one that `seg_sel_i` selects. With `REG_OUT=1`, both outputs reflect the inputs sampled at the previous rising clock edge.
- R2: Mode code 0 (direct) uses all 16 bits of `disp_i` as the offset. In this mode `disp_wide_i` and the pointer registers have no effect.
- R3: Mode code 1 (indirect) uses a single register as the offset, and `disp_i` has no effect. `ptr_sel_i` picks the register: 0 = BX, 1 = BP, 2 = SI, 3 = DI.
- R4: Mode code 2 (relative) adds the displacement to the register that `ptr_sel_i` selects. The selection is the same as in R3.
- R5: In the modes that add a displacement (2 and 4), `disp_wide_i` sets its width. When `disp_wide_i` is 1, all 16 bits of `disp_i` are used. When it is 0, only `disp_i[7:0]` is used: it is sign-extended to 16 bits, and `disp_i[15:8]` is ignored.
- R6: Mode code 3 (based indexed) adds a base register to an index register. `ptr_sel_i[0]` picks the base: 0 = BX, 1 = BP. `ptr_sel_i[1]` picks the index: 0 = SI, 1 = DI.
- R7: Mode code 4 (relative based indexed) adds the displacement to the sum of base and index. The base and index are selected as in R6.
- R8: The offset sum wraps modulo 2^16 before the segment is added.
- R9: The physical address wraps modulo 2^20.
- R10: `seg_sel_i` picks the segment value: 0 = DS, 1 = ES, 2 = SS, 3 = CS.
- R11: A clock edge with `rst_n` low sets both outputs to zero, whatever the inputs are.
- R12: Mode codes 5, 6 and 7 behave exactly like mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Addressing mode code |
| ptr_sel_i | input | 2 | Register select (single-register modes), or base select in bit 0 and index select in bit 1 |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| disp_i | input | 16 | Displacement from the instruction |
| disp_wide_i | input | 1 | 1 = 16-bit displacement, 0 = sign-extended low byte |
| ds_i | input | 16 | DS value |
| es_i | input | 16 | ES value |
| ss_i | input | 16 | SS value |
| cs_i | input | 16 | CS value |
| seg_sel_i | input | 2 | Segment select |
| ofs_o | output | 16 | Effective offset |
| phys_o | output | 20 | Physical address |

## Verification
With the default register stage, every result appears one clock after its inputs. The bench changes its inputs on a falling edge, lets one rising edge capture them, and reads both outputs on the next falling edge. A reset applied on a falling edge takes effect at the following rising edge, so the bench checks the cleared outputs on the falling edge after that. No check samples an output at the edge where it changes.

// File: rtl/seg_addr_pkg.sv
// Shared widths and mode codes for the segmented address generator.
// Assumes a 16-bit offset space and a segment shift of four bits.
package seg_addr_pkg;
    localparam int OFS_W   = 16;
    localparam int SHIFT_W = 4;
    localparam int PA_W    = OFS_W + SHIFT_W;
    localparam int SHORT_W = 8;

    typedef enum logic [2:0] {
        AM_DIRECT       = 3'd0,
        AM_INDIRECT     = 3'd1,
        AM_RELATIVE     = 3'd2,
        AM_BASE_IDX     = 3'd3,
        AM_BASE_IDX_DSP = 3'd4
    } addr_mode_e;

    typedef enum logic [1:0] {
        SEG_DS = 2'd0,
        SEG_ES = 2'd1,
        SEG_SS = 2'd2,
        SEG_CS = 2'd3
    } seg_sel_e;
endpackage

// File: rtl/seg_disp_ext.sv
// Displacement extender: passes the full word when wide is set,
// otherwise sign-extends the low short field. Purely combinational.
module seg_disp_ext #(
    parameter int OFS_W   = 16,
    parameter int SHORT_W = 8
) (
    input  logic [OFS_W-1:0] disp_i,
    input  logic             wide_i,
    output logic [OFS_W-1:0] disp_o
);
    localparam int EXT_W = OFS_W - SHORT_W;

    // Pick full word or sign-extended short field.
    always_comb begin
        if (wide_i) disp_o = disp_i;
        else        disp_o = {{EXT_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
    end
endmodule

// File: rtl/seg_offset_calc.sv
// Effective offset former: selects pointer registers per mode and adds
// the extended displacement. All sums wrap at the offset width.
// Assumes unknown mode codes fall back to direct addressing.
module seg_offset_calc #(
    parameter int OFS_W   = 16,
    parameter int SHORT_W = 8
) (
    input  logic [2:0]       mode_i,
    input  logic [1:0]       ptr_sel_i,
    input  logic [OFS_W-1:0] bx_i,
    input  logic [OFS_W-1:0] bp_i,
    input  logic [OFS_W-1:0] si_i,
    input  logic [OFS_W-1:0] di_i,
    input  logic [OFS_W-1:0] disp_i,
    input  logic             disp_wide_i,
    output logic [OFS_W-1:0] ofs_o
);
    import seg_addr_pkg::*;

    localparam int EXT_W = OFS_W - SHORT_W;

    logic [OFS_W-1:0] disp_ext;
    logic [OFS_W-1:0] single_reg;
    logic [OFS_W-1:0] base_reg;
    logic [OFS_W-1:0] index_reg;
    logic [OFS_W-1:0] pair_sum;

    seg_disp_ext #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) i_disp_ext (
        .disp_i (disp_i),
        .wide_i (disp_wide_i),
        .disp_o (disp_ext)
    );

    // Single pointer register chosen by the two-bit select.
    always_comb begin
        case (ptr_sel_i)
            2'd0:    single_reg = bx_i;
            2'd1:    single_reg = bp_i;
            2'd2:    single_reg = si_i;
            default: single_reg = di_i;
        endcase
    end

    // Base and index chosen by separate select bits, then summed.
    always_comb begin
        base_reg  = ptr_sel_i[0] ? bp_i : bx_i;
        index_reg = ptr_sel_i[1] ? di_i : si_i;
        pair_sum  = base_reg + index_reg;
    end

    // Mode decode into the final offset.
    always_comb begin
        case (mode_i)
            AM_INDIRECT:     ofs_o = single_reg;
            AM_RELATIVE:     ofs_o = single_reg + disp_ext;
            AM_BASE_IDX:     ofs_o = pair_sum;
            AM_BASE_IDX_DSP: ofs_o = pair_sum + disp_ext;
            default:         ofs_o = disp_i;
        endcase
    end

    // Check that the short displacement arrives sign-extended (R5).
    always_comb begin
        if (!disp_wide_i) begin
            assert_sext_R5: assert (disp_ext[OFS_W-1:SHORT_W] == {EXT_W{disp_i[SHORT_W-1]}});
        end
    end

    // Check that indirect mode yields one of the four pointer values (R3).
    always_comb begin
        if (mode_i == AM_INDIRECT) begin
            assert_ind_src_R3: assert (ofs_o == bx_i || ofs_o == bp_i ||
                                       ofs_o == si_i || ofs_o == di_i);
        end
    end
endmodule

// File: rtl/seg_phys_calc.sv
// Segment stage: selects a segment value, shifts it left and adds the
// offset into a physical address that wraps at its own width.
module seg_phys_calc #(
    parameter int OFS_W   = 16,
    parameter int SHIFT_W = 4
) (
    input  logic [1:0]               seg_sel_i,
    input  logic [OFS_W-1:0]         ds_i,
    input  logic [OFS_W-1:0]         es_i,
    input  logic [OFS_W-1:0]         ss_i,
    input  logic [OFS_W-1:0]         cs_i,
    input  logic [OFS_W-1:0]         ofs_i,
    output logic [OFS_W-1:0]         seg_o,
    output logic [OFS_W+SHIFT_W-1:0] phys_o
);
    import seg_addr_pkg::*;

    // Segment select.
    always_comb begin
        case (seg_sel_i)
            SEG_DS:  seg_o = ds_i;
            SEG_ES:  seg_o = es_i;
            SEG_SS:  seg_o = ss_i;
            default: seg_o = cs_i;
        endcase
    end

    // Shift-and-add, truncated to the physical width.
    always_comb begin
        phys_o = {seg_o, {SHIFT_W{1'b0}}} + {{SHIFT_W{1'b0}}, ofs_i};
    end

    // The chosen segment is always one of the four inputs (R10).
    always_comb begin
        assert_seg_src_R10: assert (seg_o == ds_i || seg_o == es_i ||
                                    seg_o == ss_i || seg_o == cs_i);
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Top of the segmented effective address generator. Combines the offset
// former and the segment stage; REG_OUT adds one output register stage
// with synchronous active-low reset. Assumes inputs are stable around
// the rising edge when the register stage is used.
module seg_addr_gen #(
    parameter int OFS_W   = 16,
    parameter int SHIFT_W = 4,
    parameter int SHORT_W = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               mode_i,
    input  logic [1:0]               ptr_sel_i,
    input  logic [OFS_W-1:0]         bx_i,
    input  logic [OFS_W-1:0]         bp_i,
    input  logic [OFS_W-1:0]         si_i,
    input  logic [OFS_W-1:0]         di_i,
    input  logic [OFS_W-1:0]         disp_i,
    input  logic                     disp_wide_i,
    input  logic [OFS_W-1:0]         ds_i,
    input  logic [OFS_W-1:0]         es_i,
    input  logic [OFS_W-1:0]         ss_i,
    input  logic [OFS_W-1:0]         cs_i,
    input  logic [1:0]               seg_sel_i,
    output logic [OFS_W-1:0]         ofs_o,
    output logic [OFS_W+SHIFT_W-1:0] phys_o
);
    localparam int PA_W = OFS_W + SHIFT_W;

    logic [OFS_W-1:0] ofs_comb;
    logic [OFS_W-1:0] seg_comb;
    logic [PA_W-1:0]  phys_comb;

    seg_offset_calc #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) i_offset (
        .mode_i      (mode_i),
        .ptr_sel_i   (ptr_sel_i),
        .bx_i        (bx_i),
        .bp_i        (bp_i),
        .si_i        (si_i),
        .di_i        (di_i),
        .disp_i      (disp_i),
        .disp_wide_i (disp_wide_i),
        .ofs_o       (ofs_comb)
    );

    seg_phys_calc #(.OFS_W(OFS_W), .SHIFT_W(SHIFT_W)) i_phys (
        .seg_sel_i (seg_sel_i),
        .ds_i      (ds_i),
        .es_i      (es_i),
        .ss_i      (ss_i),
        .cs_i      (cs_i),
        .ofs_i     (ofs_comb),
        .seg_o     (seg_comb),
        .phys_o    (phys_comb)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic chk_primed;

            // Output register stage, cleared by synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ofs_o  <= '0;
                    phys_o <= '0;
                end else begin
                    ofs_o  <= ofs_comb;
                    phys_o <= phys_comb;
                end
            end

            // Marks that one registered result has been captured after reset.
            always_ff @(posedge clk) begin
                if (!rst_n) chk_primed <= 1'b0;
                else        chk_primed <= 1'b1;
            end

            // Registered address matches the last segment plus registered offset (R1).
            assert_phys_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
                chk_primed |-> (phys_o == ({$past(seg_comb), {SHIFT_W{1'b0}}} +
                                           {{SHIFT_W{1'b0}}, ofs_o})));

            // Reset clears both outputs (R11).
            assert_reset_clear_R11: assert property (@(posedge clk)
                !rst_n |=> (ofs_o == '0 && phys_o == '0));
        end else begin : g_comb
            // Outputs follow the combinational path directly.
            always_comb begin
                ofs_o  = ofs_comb;
                phys_o = phys_comb;
            end
        end
    endgenerate
endmodule

// File: tb/test_seg_addr_gen.sv
// Directed bench for seg_addr_gen with the output register stage.
module test_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [1:0]  psel = 2'd0;
    logic [15:0] bx = 16'h0, bp = 16'h0, si = 16'h0, di = 16'h0;
    logic [15:0] disp = 16'h0;
    logic        wide = 1'b1;
    logic [15:0] ds = 16'h0, es = 16'h0, ss = 16'h0, cs = 16'h0;
    logic [1:0]  ssel = 2'd0;
    logic [15:0] ofs;
    logic [19:0] phys;

    int n_pass = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_addr_gen i_seg_addr_gen (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .ptr_sel_i(psel),
        .bx_i(bx), .bp_i(bp), .si_i(si), .di_i(di),
        .disp_i(disp), .disp_wide_i(wide),
        .ds_i(ds), .es_i(es), .ss_i(ss), .cs_i(cs),
        .seg_sel_i(ssel), .ofs_o(ofs), .phys_o(phys)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        if (act === exp) n_pass++;
        else begin
            n_fail++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    // Drive a request on a falling edge, let one rising edge capture it, read on the next falling edge.
    task automatic issue(input logic [2:0] m, input logic [1:0] p, input logic [15:0] d,
                         input logic w, input logic [1:0] s);
        @(negedge clk);
        mode = m; psel = p; disp = d; wide = w; ssel = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_regs(input logic [15:0] vbx, input logic [15:0] vbp,
                            input logic [15:0] vsi, input logic [15:0] vdi);
        bx = vbx; bp = vbp; si = vsi; di = vdi;
    endtask

    task automatic set_segs(input logic [15:0] vds, input logic [15:0] ves,
                            input logic [15:0] vss, input logic [15:0] vcs);
        ds = vds; es = ves; ss = vss; cs = vcs;
    endtask

    task automatic t_reset;
        set_regs(16'h1111, 16'h2222, 16'h3333, 16'h4444);
        set_segs(16'hABCD, 16'h0, 16'h0, 16'h0);
        mode = 3'd1; disp = 16'h7777;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset ofs", {16'h0, ofs}, 32'h0);
        check("R11 reset phys", {12'h0, phys}, 32'h0);
        rst_n = 1'b1;
        // Mid-run reset: a result is present, then a reset edge clears it.
        issue(3'd0, 2'd0, 16'h1234, 1'b1, 2'd0);
        check("R11 pre-reset ofs", {16'h0, ofs}, 32'h1234);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R11 mid-run reset phys", {12'h0, phys}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_direct;
        set_segs(16'h1005, 16'h0, 16'h0, 16'h0);
        issue(3'd0, 2'd3, 16'h5555, 1'b1, 2'd0);
        check("R2 direct ofs", {16'h0, ofs}, 32'h5555);
        check("R1 direct phys 155A5", {12'h0, phys}, 32'h155A5);
        issue(3'd0, 2'd1, 16'h80F0, 1'b0, 2'd0);
        check("R2 direct ignores width flag", {16'h0, ofs}, 32'h80F0);
    endtask

    task automatic t_indirect;
        set_regs(16'h0102, 16'h0304, 16'h0506, 16'h0708);
        set_segs(16'h0000, 16'h0000, 16'h0000, 16'h0000);
        issue(3'd1, 2'd0, 16'hFFFF, 1'b1, 2'd0);
        check("R3 indirect BX", {16'h0, ofs}, 32'h0102);
        issue(3'd1, 2'd1, 16'hFFFF, 1'b1, 2'd0);
        check("R3 indirect BP", {16'h0, ofs}, 32'h0304);
        issue(3'd1, 2'd2, 16'hFFFF, 1'b0, 2'd0);
        check("R3 indirect SI", {16'h0, ofs}, 32'h0506);
        issue(3'd1, 2'd3, 16'hFFFF, 1'b1, 2'd0);
        check("R3 indirect DI", {16'h0, ofs}, 32'h0708);
    endtask

    task automatic t_relative;
        set_regs(16'h1000, 16'h2000, 16'h3000, 16'h4000);
        issue(3'd2, 2'd0, 16'h00F0, 1'b0, 2'd0);
        check("R5 short negative disp", {16'h0, ofs}, 32'h0FF0);
        issue(3'd2, 2'd0, 16'hAB7F, 1'b0, 2'd0);
        check("R5 short disp upper byte ignored", {16'h0, ofs}, 32'h107F);
        issue(3'd2, 2'd0, 16'h00F0, 1'b1, 2'd0);
        check("R5 wide disp", {16'h0, ofs}, 32'h10F0);
        issue(3'd2, 2'd3, 16'h0234, 1'b1, 2'd0);
        check("R4 relative DI", {16'h0, ofs}, 32'h4234);
        issue(3'd2, 2'd1, 16'h0080, 1'b0, 2'd0);
        check("R4 relative BP short", {16'h0, ofs}, 32'h1F80);
    endtask

    task automatic t_based;
        set_regs(16'h2000, 16'h0100, 16'h3000, 16'h0040);
        set_segs(16'h1000, 16'h2000, 16'h3000, 16'h4000);
        issue(3'd3, 2'b00, 16'hFFFF, 1'b1, 2'd0);
        check("R6 BX+SI", {16'h0, ofs}, 32'h5000);
        issue(3'd3, 2'b11, 16'hFFFF, 1'b1, 2'd0);
        check("R6 BP+DI", {16'h0, ofs}, 32'h0140);
        issue(3'd3, 2'b01, 16'h0000, 1'b1, 2'd0);
        check("R6 BP+SI", {16'h0, ofs}, 32'h3100);
        issue(3'd4, 2'b00, 16'h5000, 1'b1, 2'd0);
        check("R7 example ofs", {16'h0, ofs}, 32'hA000);
        check("R7 example phys 1A000", {12'h0, phys}, 32'h1A000);
        issue(3'd4, 2'b10, 16'h00FE, 1'b0, 2'd0);
        check("R7 BX+DI short disp", {16'h0, ofs}, 32'h203E);
    endtask

    task automatic t_wrap;
        set_regs(16'hFFFF, 16'h0, 16'h0002, 16'h0);
        set_segs(16'h0000, 16'h0, 16'h0, 16'hFFFF);
        issue(3'd3, 2'b00, 16'h0, 1'b1, 2'd0);
        check("R8 offset wraps", {16'h0, ofs}, 32'h0001);
        check("R8 phys uses wrapped offset", {12'h0, phys}, 32'h00001);
        issue(3'd0, 2'd0, 16'hFFFF, 1'b1, 2'd3);
        check("R9 phys wraps", {12'h0, phys}, 32'h0FFEF);
    endtask

    task automatic t_segsel;
        set_segs(16'h1000, 16'h2000, 16'h3000, 16'h4000);
        issue(3'd0, 2'd0, 16'h0012, 1'b1, 2'd0);
        check("R10 DS", {12'h0, phys}, 32'h10012);
        issue(3'd0, 2'd0, 16'h0012, 1'b1, 2'd1);
        check("R10 ES", {12'h0, phys}, 32'h20012);
        issue(3'd0, 2'd0, 16'h0012, 1'b1, 2'd2);
        check("R10 SS", {12'h0, phys}, 32'h30012);
        issue(3'd0, 2'd0, 16'h0012, 1'b1, 2'd3);
        check("R10 CS", {12'h0, phys}, 32'h40012);
    endtask

    task automatic t_reserved;
        set_regs(16'h1111, 16'h2222, 16'h3333, 16'h4444);
        issue(3'd5, 2'd0, 16'h1234, 1'b0, 2'd0);
        check("R12 mode 5 as direct", {16'h0, ofs}, 32'h1234);
        issue(3'd6, 2'd2, 16'h00C0, 1'b0, 2'd0);
        check("R12 mode 6 as direct", {16'h0, ofs}, 32'h00C0);
        issue(3'd7, 2'd3, 16'hBEEF, 1'b1, 2'd1);
        check("R12 mode 7 as direct", {16'h0, ofs}, 32'hBEEF);
    endtask

    initial begin
        t_reset;
        t_direct;
        t_indirect;
        t_relative;
        t_based;
        t_wrap;
        t_segsel;
        t_reserved;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
            $finish;
        end
    end
endmodule